// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken by running two direction predictors side by side and letting a third table decide which one to believe. The first predictor is driven by a 12-bit history of the most recent branch outcomes across the whole program. That history indexes 4096 two-bit counters. The second predictor works in two levels. A table of 1024 ten-bit per-branch histories is selected by PC bits [11:2]. The selected history then picks one of 1024 three-bit counters. A chooser of 4096 two-bit counters, indexed by the same global history, selects the component whose answer is output.

The fetch side is purely combinational. It takes `fetch_pc` and returns the final prediction along with both component guesses. The pipeline carries the two component guesses with the branch. When the branch resolves, the pipeline presents the branch PC, the real outcome and those two guesses on the resolve port. In that single clock edge the block trains both component counters, trains the chooser when the components disagreed, and shifts the outcome into the global history and into the branch's local history.

The tables have no reset of their own. After reset a small controller sweeps through them. It starts in state `S_CLEAR`, where one index of every table is written with its reset value each cycle and resolves are ignored. When the sweep index reaches its last value the controller takes the transition `sweep_done` to `S_READY`. It stays in `S_READY` until the next reset, which takes the transition `reset` back to `S_CLEAR` from either state.

Top module: `tournament_bp`

## Requirements
- R1: After reset is released, `ready` stays low for exactly 4096 clock cycles and then stays high. While `ready` is low, `pred_taken` is 0 and resolves have no effect.
- R2: Once the sweep has finished, every global counter and chooser counter holds 1 and every local counter holds 3, so every PC predicts not-taken on `pred_global`, `pred_local` and `pred_taken`. All histories are zero. This holds even after a run that trained the tables.
- R3: `pred_global` is the MSB of the 2-bit global counter indexed by the current 12-bit global history. On a resolve that counter steps toward `res_taken`.
- R4: On each accepted resolve the global history shifts left by one, and `res_taken` enters bit 0 (1 = taken).
- R5: The local history entry selected by `res_pc[11:2]` shifts left on a resolve, with `res_taken` entering bit 0. Fetch selects the entry with `fetch_pc[11:2]`.
- R6: `pred_local` is 1 when the 3-bit local counter indexed by the fetch PC's local history is 4 or more. On a resolve, the counter indexed by the resolving branch's local history steps toward `res_taken`.
- R7: `pred_taken` equals `pred_global` when the chooser counter at the current global history has MSB 1, and equals `pred_local` otherwise. The chooser changes only when `res_gpred` differs from `res_lpred`. It steps up when `res_gpred` matches the outcome and down otherwise.
- R8: Every counter saturates: a 2-bit counter never goes below 0 or above 3, and a 3-bit counter never goes below 0 or above 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ready | output | 1 | High once the table sweep has finished |
| fetch_pc | input | 32 | PC of the branch being fetched |
| pred_taken | output | 1 | Final direction prediction |
| pred_global | output | 1 | Global component prediction |
| pred_local | output | 1 | Local component prediction |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | PC of the resolving branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_gpred | input | 1 | Global prediction made for this branch at fetch |
| res_lpred | input | 1 | Local prediction made for this branch at fetch |

## Verification
Each input pattern is compared against a reference model of the tables and histories that the bench keeps itself.

- A mixed table of PCs and outcomes exercises global history aliasing against per-PC histories. Several branches share chooser entries there, so chooser training is visible.
- A single branch that is always taken and then never taken drives the counters into both rails. This separates saturating behaviour from wrap-around.
- A loop-like taken-taken-taken-not pattern at one PC is something only the local history can learn. It shows whether the local histories are indexed and shifted correctly and whether the chooser moves toward the component that was right.
- A reset after training, followed by the sweep count, shows that the sweep really restores every table.

// File: rtl/tp_pkg.sv
package tp_pkg;
    typedef enum logic {
        S_CLEAR = 1'b0,
        S_READY = 1'b1
    } tp_state_e;
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
    parameter int IDX_W = 12,
    parameter int CNT_W = 2,
    parameter int INIT  = 1
) (
    input  logic             clk,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] RSTV = CNT_W'(INIT);

    logic [CNT_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] nxt;

    assign rd_val = mem[rd_idx];
    assign cur    = mem[wr_idx];

    always_comb begin
        if (wr_up) nxt = (cur == MAXV) ? cur : cur + 1'b1;
        else       nxt = (cur == '0)   ? cur : cur - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (clr_en)     mem[clr_idx] <= RSTV;
        else if (wr_en) mem[wr_idx]  <= nxt;
    end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
    parameter int IDX_W = 10,
    parameter int H_W   = 10
) (
    input  logic             clk,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [H_W-1:0]   rd_hist,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [H_W-1:0]   wr_hist,
    input  logic             wr_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [H_W-1:0] mem [DEPTH];

    assign rd_hist = mem[rd_idx];
    assign wr_hist = mem[wr_idx];

    always_ff @(posedge clk) begin
        if (clr_en)     mem[clr_idx] <= '0;
        else if (wr_en) mem[wr_idx]  <= {wr_hist[H_W-2:0], wr_bit};
    end
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp #(
    parameter int PC_W = 32,
    parameter int GH_W = 12,
    parameter int LA_W = 10,
    parameter int LH_W = 10,
    parameter int GC_W = 2,
    parameter int LC_W = 3,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            ready,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic            pred_global,
    output logic            pred_local,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic            res_gpred,
    input  logic            res_lpred
);
    import tp_pkg::*;

    localparam int MAX_AL  = (GH_W > LA_W) ? GH_W : LA_W;
    localparam int CLR_W   = (MAX_AL > LH_W) ? MAX_AL : LH_W;
    localparam logic [CLR_W-1:0] CLR_LAST = {CLR_W{1'b1}};
    localparam int GC_INIT = (1 << (GC_W - 1)) - 1;
    localparam int LC_INIT = (1 << (LC_W - 1)) - 1;
    localparam int CH_INIT = (1 << (CH_W - 1)) - 1;

    tp_state_e        state, state_nx;
    logic [CLR_W-1:0] sweep;
    logic             clr_en;
    logic             upd;
    logic [GH_W-1:0]  ghist;

    logic [GC_W-1:0]  gc_val;
    logic [LC_W-1:0]  lc_val;
    logic [CH_W-1:0]  ch_val;
    logic [LH_W-1:0]  lh_fetch;
    logic [LH_W-1:0]  lh_res;
    logic [LA_W-1:0]  la_fetch;
    logic [LA_W-1:0]  la_res;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_CLEAR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_CLEAR: if (sweep == CLR_LAST) state_nx = S_READY;
            S_READY: state_nx = S_READY;
        endcase
    end

    // outputs of the controller
    always_comb begin
        clr_en = 1'b0;
        ready  = 1'b0;
        unique case (state)
            S_CLEAR: clr_en = 1'b1;
            S_READY: ready  = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      sweep <= '0;
        else if (clr_en) sweep <= sweep + 1'b1;
    end

    assign upd = ready && res_valid;

    always_ff @(posedge clk) begin
        if (!rst_n)   ghist <= '0;
        else if (upd) ghist <= {ghist[GH_W-2:0], res_taken};
    end

    assign la_fetch = fetch_pc[LA_W+1:2];
    assign la_res   = res_pc[LA_W+1:2];

    tp_ctr_table #(.IDX_W(GH_W), .CNT_W(GC_W), .INIT(GC_INIT)) u_gctr (
        .clk(clk), .clr_en(clr_en), .clr_idx(sweep[GH_W-1:0]),
        .rd_idx(ghist), .rd_val(gc_val),
        .wr_en(upd), .wr_idx(ghist), .wr_up(res_taken)
    );

    tp_hist_table #(.IDX_W(LA_W), .H_W(LH_W)) u_lhist (
        .clk(clk), .clr_en(clr_en), .clr_idx(sweep[LA_W-1:0]),
        .rd_idx(la_fetch), .rd_hist(lh_fetch),
        .wr_en(upd), .wr_idx(la_res), .wr_hist(lh_res), .wr_bit(res_taken)
    );

    tp_ctr_table #(.IDX_W(LH_W), .CNT_W(LC_W), .INIT(LC_INIT)) u_lctr (
        .clk(clk), .clr_en(clr_en), .clr_idx(sweep[LH_W-1:0]),
        .rd_idx(lh_fetch), .rd_val(lc_val),
        .wr_en(upd), .wr_idx(lh_res), .wr_up(res_taken)
    );

    tp_ctr_table #(.IDX_W(GH_W), .CNT_W(CH_W), .INIT(CH_INIT)) u_chooser (
        .clk(clk), .clr_en(clr_en), .clr_idx(sweep[GH_W-1:0]),
        .rd_idx(ghist), .rd_val(ch_val),
        .wr_en(upd && (res_gpred != res_lpred)), .wr_idx(ghist),
        .wr_up(res_gpred == res_taken)
    );

    assign pred_global = gc_val[GC_W-1];
    assign pred_local  = lc_val[LC_W-1];
    assign pred_taken  = ready && (ch_val[CH_W-1] ? pred_global : pred_local);
endmodule

// File: rtl/tournament_bp_chk.sv
module tournament_bp_chk #(
    parameter int GH_W = 12,
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ready,
    input logic            pred_taken,
    input logic            pred_global,
    input logic            pred_local,
    input logic            res_valid,
    input logic            res_taken,
    input logic [GH_W-1:0] ghist,
    input logic [CH_W-1:0] ch_val
);
    p_ready_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ready) |-> ready);

    p_quiet_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !pred_taken);

    p_hist_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready || !res_valid) |=> $stable(ghist));

    p_ghist_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && res_valid) |=>
            (ghist[0] == $past(res_taken)) &&
            (ghist[GH_W-1:1] == $past(ghist[GH_W-2:0])));

    p_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (pred_taken == (ch_val[CH_W-1] ? pred_global : pred_local)));
endmodule

bind tournament_bp tournament_bp_chk #(.GH_W(GH_W), .CH_W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .pred_taken(pred_taken),
    .pred_global(pred_global), .pred_local(pred_local),
    .res_valid(res_valid), .res_taken(res_taken),
    .ghist(ghist), .ch_val(ch_val)
);

// File: tb/sim_tournament_bp.sv
module sim_tournament_bp;
    localparam int CLK_P = 10;
    localparam int SWEEP = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ready;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken, pred_global, pred_local;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic        res_gpred = 1'b0;
    logic        res_lpred = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model
    logic [1:0]  m_gc [4096];
    logic [2:0]  m_lc [1024];
    logic [1:0]  m_ch [4096];
    logic [9:0]  m_lh [1024];
    logic [11:0] m_gh;

    localparam logic [32:0] VEC [16] = '{
        {32'h0000_1000, 1'b1}, {32'h0000_1040, 1'b0},
        {32'h0000_1000, 1'b1}, {32'h0000_10c4, 1'b1},
        {32'h0000_1040, 1'b1}, {32'h0000_1000, 1'b0},
        {32'h0000_2ff8, 1'b1}, {32'h0000_10c4, 1'b0},
        {32'h0000_1000, 1'b1}, {32'h0000_1040, 1'b0},
        {32'h0000_2ff8, 1'b1}, {32'h0000_10c4, 1'b1},
        {32'h0000_1000, 1'b1}, {32'h0000_1040, 1'b1},
        {32'h0000_2ff8, 1'b0}, {32'h0000_10c4, 1'b0}
    };

    tournament_bp u0 (
        .clk(clk), .rst_n(rst_n), .ready(ready), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_global(pred_global), .pred_local(pred_local),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_gpred(res_gpred), .res_lpred(res_lpred)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4096; i++) begin m_gc[i] = 2'd1; m_ch[i] = 2'd1; end
        for (int i = 0; i < 1024; i++) begin m_lc[i] = 3'd3; m_lh[i] = '0; end
        m_gh = '0;
    endtask

    function automatic logic [1:0] sat2(input logic [1:0] v, input logic up);
        if (up) return (v == 2'd3) ? v : v + 2'd1;
        return (v == 2'd0) ? v : v - 2'd1;
    endfunction

    function automatic logic [2:0] sat3(input logic [2:0] v, input logic up);
        if (up) return (v == 3'd7) ? v : v + 3'd1;
        return (v == 3'd0) ? v : v - 3'd1;
    endfunction

    task automatic do_reset();
        int cnt;
        @(negedge clk);
        rst_n = 1'b0;
        res_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(ready, 1'b0, "R1 ready low in reset");
        rst_n = 1'b1;
        model_reset();
        cnt = 0;
        while (!ready && cnt < SWEEP + 10) begin
            @(posedge clk);
            cnt++;
            #1;
            if (cnt == 100) begin
                chk(pred_taken, 1'b0, "R1 no prediction during sweep");
                res_valid = 1'b1; res_pc = 32'h0000_1000; res_taken = 1'b1;
                res_gpred = 1'b1; res_lpred = 1'b0;
            end
            if (cnt == 200) res_valid = 1'b0;
        end
        checks++;
        if (cnt != SWEEP) begin
            errors++;
            $display("FAIL R1 sweep length: actual %0d expected %0d", cnt, SWEEP);
        end
    endtask

    task automatic step(input logic [31:0] pc, input logic tk, input string tag);
        logic [9:0] li;
        logic eg, el, ep;
        @(negedge clk);
        fetch_pc = pc;
        #1;
        li = pc[11:2];
        eg = m_gc[m_gh][1];
        el = (m_lc[m_lh[li]] >= 3'd4);
        ep = m_ch[m_gh][1] ? eg : el;
        chk(pred_global, eg, {tag, " R3 R4 global"});
        chk(pred_local,  el, {tag, " R5 R6 local"});
        chk(pred_taken,  ep, {tag, " R7 final"});
        res_valid = 1'b1; res_pc = pc; res_taken = tk;
        res_gpred = eg;   res_lpred = el;
        @(posedge clk);
        #1;
        res_valid = 1'b0;
        m_gc[m_gh] = sat2(m_gc[m_gh], tk);
        m_lc[m_lh[li]] = sat3(m_lc[m_lh[li]], tk);
        if (eg != el) m_ch[m_gh] = sat2(m_ch[m_gh], eg == tk);
        m_lh[li] = {m_lh[li][8:0], tk};
        m_gh = {m_gh[10:0], tk};
    endtask

    task automatic cold_look(input logic [31:0] pc, input string tag);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        chk(pred_global, 1'b0, {tag, " R2 global cold"});
        chk(pred_local,  1'b0, {tag, " R2 local cold"});
        chk(pred_taken,  1'b0, {tag, " R2 final cold"});
    endtask

    initial begin
        do_reset();
        cold_look(32'h0000_1000, "first");
        cold_look(32'h0000_2ff8, "first");

        // vector table walk
        for (int pass = 0; pass < 8; pass++)
            for (int i = 0; i < 16; i++)
                step(VEC[i][32:1], VEC[i][0], "vec");

        // saturation on one branch
        for (int i = 0; i < 24; i++) step(32'h0000_2040, 1'b1, "R8 up");
        for (int i = 0; i < 24; i++) step(32'h0000_2040, 1'b0, "R8 down");

        // loop pattern T T T N at one PC
        for (int i = 0; i < 48; i++) step(32'h0000_3000, (i % 4) != 3, "loop");

        // mixed again after loop training
        for (int i = 0; i < 16; i++) step(VEC[i][32:1], VEC[i][0], "mix");

        // reset after training restores tables
        do_reset();
        cold_look(32'h0000_2040, "retrain");
        cold_look(32'h0000_3000, "retrain");
        cold_look(32'h0000_1000, "retrain");
        for (int i = 0; i < 8; i++) step(32'h0000_3000, 1'b1, "post");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule